// File: doc/BRIEF.md
# Configurable Sync Word Matcher

This block sits behind a preamble detector in a packet receiver. A one-cycle preamble-detect pulse arms it. It then takes in the demodulated bit stream one qualified bit at a time. It looks for a programmable synchronization word of one to four bytes. The word always begins with the highest sync byte. Further bytes follow in descending order, and each byte arrives most-significant bit first.

A match produces a one-cycle found pulse, after which the block idles. The search window is bounded. If the word has not appeared by the time the configured word length plus four extra bits have been received, the block raises a one-cycle timeout pulse, which tells the preamble detector to begin hunting again. A new preamble-detect pulse always restarts the search from a clean state.

Top module: `syncword_matcher`

## Requirements
- R1: After reset both result pulses are low and the block is idle, so qualified bits arriving before any preamble-detect pulse produce no pulse.
- R2: With length code 0 the expected word is the single byte at `syncBytes[31:24]`.
- R3: With length code 3 the expected word is 32 bits: `syncBytes[31:24]` on air first, then `[23:16]`, `[15:8]` and finally `[7:0]`, each byte most-significant bit first.
- R4: Length codes 1 and 2 expect the top two bytes (`[31:16]`) and the top three bytes (`[31:8]`) respectively, in the same order.
- R5: The comparison uses only the most recent 8×(code+1) bits received since arming, so leading bits of any value ahead of the word do not prevent a match inside the window.
- R6: If 8×(code+1)+4 bits have been counted since arming without a match, `syncTimeout` pulses for exactly one cycle, one cycle after the last bit is accepted.
- R7: A match completed on the last bit of the window (bit 8×(code+1)+4) reports found and not timeout.
- R8: `syncFound` pulses for one cycle, one cycle after the bit that completes the word. It never coincides with `syncTimeout`, and each search produces at most one pulse.
- R9: After a found or timeout pulse, further bits produce no pulse until the next preamble-detect pulse.
- R10: A preamble-detect pulse restarts the bit count and discards bit history, even in the middle of a search. A bit offered in the same cycle as the pulse is not counted.
- R11: Only cycles with `bitValid` high advance the bit count or the history. `bitIn` is ignored in the other cycles.
- R12: The length code is captured at the preamble-detect pulse, and later changes to `syncLenSel` do not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preambleDet | input | 1 | One-cycle pulse that arms or re-arms the search |
| bitValid | input | 1 | Qualifies `bitIn` for this cycle |
| bitIn | input | 1 | Received data bit |
| syncLenSel | input | 2 | Word length code: number of sync bytes minus one |
| syncBytes | input | 32 | Expected sync bytes; the top byte is sent first |
| syncFound | output | 1 | One-cycle pulse on a match |
| syncTimeout | output | 1 | One-cycle pulse when the window expires unmatched |

## Verification
The bench aims at the window edges. A word that completes on the very last allowed bit must report found; an off-by-one bound would report a timeout instead or let the search run on. A word that starts one bit too late must time out at exactly bit 8×(code+1)+4. A re-arm in the middle of a word is tested so that a matcher keeping stale history would find a word split across the re-arm. A bit offered alongside the arm pulse is tested so that counting it would move the timeout one bit early. Idle gaps with a toggling `bitIn` are inserted between bits, and the length code is changed after arming, to expose a matcher that shifts on every cycle or reads the length code live.

// File: rtl/smatch_pkg.sv
package smatch_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic arm;
    logic shiftEn;
  } smStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HUNT = 1'b1
  } smState_t;

endpackage

// File: rtl/smatch_datapath.sv
module smatch_datapath
  import smatch_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAX_BYTES  = 4,
  parameter int SLACK_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  smStrobe_t                     strobe,
  input  logic                          bitIn,
  input  logic [$clog2(MAX_BYTES)-1:0]  lenSel,
  input  logic [BYTE_W*MAX_BYTES-1:0]   syncBytes,
  output logic                          hitNext,
  output logic                          endNext
);

  localparam int SHIFT_W = BYTE_W * MAX_BYTES;
  localparam int SEL_W   = $clog2(MAX_BYTES);
  localparam int CNT_W   = $clog2(SHIFT_W + SLACK_BITS + 1);

  logic [SHIFT_W-1:0]   histQ, histNext;
  logic [CNT_W-1:0]     cntQ, cntNext;
  logic [SEL_W-1:0]     lenQ;
  logic [MAX_BYTES-1:0] eqVec;
  logic [CNT_W-1:0]     needBits, endBits;

  always_comb begin
    histNext = histQ;
    cntNext  = cntQ;
    if (strobe.shiftEn) begin
      histNext = {histQ[SHIFT_W-2:0], bitIn};
      cntNext  = cntQ + 1'b1;
    end
  end

  // One comparator per candidate word length; the newest bit is the LSB.
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_cmp
    assign eqVec[g] = (histNext[(g+1)*BYTE_W-1:0] ==
                       syncBytes[SHIFT_W-1 -: (g+1)*BYTE_W]);
  end

  always_comb begin
    needBits = CNT_W'((int'(lenQ) + 1) * BYTE_W);
    endBits  = needBits + CNT_W'(SLACK_BITS);
  end

  assign hitNext = strobe.shiftEn && eqVec[lenQ] && (cntNext >= needBits);
  assign endNext = strobe.shiftEn && (cntNext >= endBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
      cntQ  <= '0;
      lenQ  <= '0;
    end else if (strobe.arm) begin
      histQ <= '0;
      cntQ  <= '0;
      lenQ  <= lenSel;
    end else if (strobe.shiftEn) begin
      histQ <= histNext;
      cntQ  <= cntNext;
    end
  end

  // R11: count advances by exactly one per accepted bit
  p_count_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && !strobe.arm) |=> cntQ == CNT_W'($past(cntQ) + 1'b1));

  // R11: no accepted bit, no change
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.shiftEn && !strobe.arm) |=> ($stable(cntQ) && $stable(histQ)));

  // R10: arming wipes count and history
  p_arm_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> (cntQ == '0 && histQ == '0));

  // R12: length only changes on arm
  p_len_latch_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.arm |=> $stable(lenQ));

endmodule

// File: rtl/smatch_control.sv
module smatch_control
  import smatch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      preambleDet,
  input  logic      bitValid,
  input  logic      hitNext,
  input  logic      endNext,
  output smStrobe_t strobe,
  output logic      syncFound,
  output logic      syncTimeout
);

  smState_t stateQ;

  always_comb begin
    strobe.arm     = preambleDet;
    strobe.shiftEn = (stateQ == ST_HUNT) && bitValid && !preambleDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      syncFound   <= 1'b0;
      syncTimeout <= 1'b0;
    end else begin
      syncFound   <= hitNext;
      syncTimeout <= endNext && !hitNext;
      if (preambleDet) begin
        stateQ <= ST_HUNT;
      end else if (hitNext || endNext) begin
        stateQ <= ST_IDLE;
      end
    end
  end

  // R8: the two results never coincide
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(syncFound && syncTimeout));

  // R8: found is a single-cycle pulse
  p_found_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |=> !syncFound);

  // R6: timeout is a single-cycle pulse
  p_timeout_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    syncTimeout |=> !syncTimeout);

  // R9: any result leaves the matcher idle
  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rstN)
    (syncFound || syncTimeout) |-> stateQ == ST_IDLE);

endmodule

// File: rtl/syncword_matcher.sv
module syncword_matcher
  import smatch_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int MAX_BYTES  = 4,
  parameter int SLACK_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          preambleDet,
  input  logic                          bitValid,
  input  logic                          bitIn,
  input  logic [$clog2(MAX_BYTES)-1:0]  syncLenSel,
  input  logic [BYTE_W*MAX_BYTES-1:0]   syncBytes,
  output logic                          syncFound,
  output logic                          syncTimeout
);

  smStrobe_t strobe;
  logic      hitNext;
  logic      endNext;

  smatch_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .preambleDet (preambleDet),
    .bitValid    (bitValid),
    .hitNext     (hitNext),
    .endNext     (endNext),
    .strobe      (strobe),
    .syncFound   (syncFound),
    .syncTimeout (syncTimeout)
  );

  smatch_datapath #(
    .BYTE_W     (BYTE_W),
    .MAX_BYTES  (MAX_BYTES),
    .SLACK_BITS (SLACK_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitIn     (bitIn),
    .lenSel    (syncLenSel),
    .syncBytes (syncBytes),
    .hitNext   (hitNext),
    .endNext   (endNext)
  );

endmodule

// File: tb/syncword_matcher_tb.sv
module syncword_matcher_tb;

  localparam logic [31:0] PAT = 32'hD3912C5A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        preambleDet = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [1:0]  syncLenSel = 2'd0;
  logic [31:0] syncBytes = PAT;
  logic        syncFound;
  logic        syncTimeout;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  syncword_matcher u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .preambleDet (preambleDet),
    .bitValid    (bitValid),
    .bitIn       (bitIn),
    .syncLenSel  (syncLenSel),
    .syncBytes   (syncBytes),
    .syncFound   (syncFound),
    .syncTimeout (syncTimeout)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] patBits(input int sel);
    return 64'(PAT >> (32 - 8 * (sel + 1)));
  endfunction

  task automatic arm(input logic [1:0] sel, input logic withBit, input logic val);
    preambleDet = 1'b1;
    syncLenSel  = sel;
    bitValid    = withBit;
    bitIn       = val;
    @(posedge clk);
    @(negedge clk);
    preambleDet = 1'b0;
    bitValid    = 1'b0;
  endtask

  // Sends n bits (bits[n-1] first); indices of pulses are 1-based bit numbers.
  task automatic sendSeq(input logic [63:0] bits, input int n, input int gap,
                         output int fIdx, output int tIdx,
                         output int fCnt, output int tCnt);
    fIdx = 0; tIdx = 0; fCnt = 0; tCnt = 0;
    for (int i = 0; i < n; i++) begin
      bitValid = 1'b1;
      bitIn    = bits[n-1-i];
      @(posedge clk);
      @(negedge clk);
      bitValid = 1'b0;
      if (syncFound)   begin fCnt++; if (fIdx == 0) fIdx = i + 1; end
      if (syncTimeout) begin tCnt++; if (tIdx == 0) tIdx = i + 1; end
      for (int g = 0; g < gap; g++) begin
        bitIn = ~bitIn;
        @(posedge clk);
        @(negedge clk);
        if (syncFound)   fCnt++;
        if (syncTimeout) tCnt++;
      end
    end
  endtask

  task automatic t_reset();
    int f, t, fc, tc;
    checkEq("R1 found low after reset", int'(syncFound), 0);
    checkEq("R1 timeout low after reset", int'(syncTimeout), 0);
    sendSeq(64'(PAT), 32, 0, f, t, fc, tc);
    checkEq("R1 no found before arm", fc, 0);
    checkEq("R1 no timeout before arm", tc, 0);
  endtask

  task automatic t_length(input int sel, input string req);
    int f, t, fc, tc, n;
    n = 8 * (sel + 1) + 3;
    arm(2'(sel), 1'b0, 1'b0);
    sendSeq(patBits(sel), n, 0, f, t, fc, tc);
    checkEq({req, " found on last word bit"}, f, n);
    checkEq({"R8 single found ", req}, fc, 1);
    checkEq({"R8 no timeout ", req}, tc, 0);
  endtask

  task automatic t_lastBit();
    int f, t, fc, tc;
    arm(2'd1, 1'b0, 1'b0);
    sendSeq(patBits(1), 20, 0, f, t, fc, tc);
    checkEq("R7 found on final window bit", f, 20);
    checkEq("R7 no timeout on final bit match", tc, 0);
  endtask

  task automatic t_timeout();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(64'd0, 12, 0, f, t, fc, tc);
    checkEq("R6 timeout at bit 12", t, 12);
    checkEq("R6 single timeout", tc, 1);
    checkEq("R6 no found", fc, 0);
    sendSeq(patBits(0), 8, 0, f, t, fc, tc);
    checkEq("R9 no found after timeout", fc, 0);
    checkEq("R9 no timeout after timeout", tc, 0);
  endtask

  task automatic t_afterFound();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(patBits(0), 8, 0, f, t, fc, tc);
    checkEq("R9 first found", f, 8);
    sendSeq(patBits(0), 8, 0, f, t, fc, tc);
    checkEq("R9 no second found", fc, 0);
    checkEq("R9 no timeout while idle", tc, 0);
  endtask

  task automatic t_late();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(patBits(0), 13, 0, f, t, fc, tc);
    checkEq("R5 late word times out at bit 12", t, 12);
    checkEq("R5 late word not found", fc, 0);
  endtask

  task automatic t_rearm();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(64'hD, 4, 0, f, t, fc, tc);
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(64'h300, 12, 0, f, t, fc, tc);
    checkEq("R10 history discarded on re-arm", fc, 0);
    checkEq("R10 count restarted on re-arm", t, 12);
  endtask

  task automatic t_sameCycle();
    int f, t, fc, tc;
    arm(2'd0, 1'b1, 1'b0);
    sendSeq(64'd0, 12, 0, f, t, fc, tc);
    checkEq("R10 bit with arm not counted", t, 12);
  endtask

  task automatic t_gaps();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    sendSeq(patBits(0), 8, 3, f, t, fc, tc);
    checkEq("R11 found with idle gaps", f, 8);
    checkEq("R11 single found with gaps", fc, 1);
    checkEq("R11 no timeout with gaps", tc, 0);
  endtask

  task automatic t_latch();
    int f, t, fc, tc;
    arm(2'd0, 1'b0, 1'b0);
    syncLenSel = 2'd3;
    sendSeq(patBits(0), 8, 0, f, t, fc, tc);
    checkEq("R12 length captured at arm", f, 8);
    checkEq("R12 no timeout", tc, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_length(0, "R2");
    t_length(1, "R4 two bytes");
    t_length(2, "R4 three bytes");
    t_length(3, "R3");
    t_lastBit();
    t_timeout();
    t_afterFound();
    t_late();
    t_rearm();
    t_sameCycle();
    t_gaps();
    t_latch();
    summary();
  end

endmodule